// File: doc/BRIEF.md
# Memory Region Attribute Remap Unit

This block keeps a 32-bit primary remap control word and uses it to turn the short-descriptor region attribute bits of a translation (TEX[0], C, B and S) into a resolved memory type and a shareability result. The three bits TEX[0], C and B form an attribute index. The index selects a 2-bit memory type field and a shareability domain bit from the control word. Two bits of the word resolve the S bit for Normal memory.

There is one copy of the word for each security state, Secure and Non-secure. Software reaches the copy that matches its current security state through a single-cycle access port. The port is gated by exception level and by the translation format in use. A lookup port picks its copy by the lookup's own security input and returns the result combinationally. Refused accesses and lookups that reach the reserved type encoding each raise a one-cycle error pulse.

Reset is asserted asynchronously and released through a two-stage synchronizer inside the block. The block accepts accesses from the third rising clock edge after `rst_n` goes high.

Top module: `attr_remap_unit`

## Requirements
- R1: The attribute index is n = {TEX[0], C, B}, with TEX[0] as the most significant bit. `lkp_type` is control bits [2n+1:2n] of the selected copy. The encodings are 00 strongly ordered device, 01 other device, 10 Normal and 11 reserved.
- R2: For Normal memory, `lkp_shareable` is control bit 19 when S=1 and control bit 18 when S=0.
- R3: For Normal shareable memory, `lkp_inner` is control bit 24+n, where 1 means inner and 0 means outer. For Normal non-shareable memory, `lkp_inner` is 0.
- R4: For Device types (00 and 01), `lkp_shareable` is 1 and `lkp_inner` is 0. Control bits 17 and 16 are stored and read back but never change a lookup result.
- R5: Control bits [23:20] always read as zero. Write data on those bits is discarded.
- R6: The Secure copy (`*_ns`=0) and the Non-secure copy (`*_ns`=1) are separate. Accesses select a copy with `cfg_ns` and lookups select one with `lkp_ns`.
- R7: An access with `cfg_el` below MIN_EL (default 1, so only level 0) is refused. A refused write changes no copy, a refused read returns zero, and `cfg_err` is 1 for exactly the cycle after the request.
- R8: Every access made while `cfg_long_desc` is 1 is refused in the same way as in R7.
- R9: A valid lookup whose type field is 11 returns `lkp_type`=11 with `lkp_shareable`=0 and `lkp_inner`=0, and `lkp_err` is 1 for exactly the cycle after it.
- R10: Both copies reset to zero. A granted write becomes visible to reads and lookups from the next clock edge. A granted read returns the copy in the same cycle, and `cfg_rdata` is zero when no granted read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Access request strobe |
| cfg_we | input | 1 | 1 for a write, 0 for a read |
| cfg_el | input | 2 | Exception level of the requester |
| cfg_ns | input | 1 | Security state of the requester (1 = Non-secure) |
| cfg_long_desc | input | 1 | Long-descriptor translation format active |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (zero unless a granted read) |
| cfg_err | output | 1 | Pulse one cycle after a refused access |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_ns | input | 1 | Security state of the lookup |
| lkp_tex0 | input | 1 | Descriptor TEX[0] bit |
| lkp_c | input | 1 | Descriptor C bit |
| lkp_b | input | 1 | Descriptor B bit |
| lkp_s | input | 1 | Descriptor S bit |
| lkp_type | output | 2 | Resolved memory type |
| lkp_shareable | output | 1 | Resolved shareable flag |
| lkp_inner | output | 1 | 1 = inner shareable, 0 = outer |
| lkp_err | output | 1 | Pulse one cycle after a reserved-type lookup |

## Verification
The bench builds the block with its default parameters: MIN_EL of 1, a 2-bit level input and two security copies. With these values, every level from 0 to 3 can be driven, so both the refused level and all the granted levels are exercised. Random write data reaches every combination of type field, S mapping and domain bit in both copies, including the reserved type 11 and the ignored bits 17, 16 and [23:20]. Directed steps cover an all-ones write, copy isolation, refusal under the long-descriptor format, and a check that the device mapping bits have no effect on lookups.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_IDX    = 8;
  localparam int IDX_W      = $clog2(NUM_IDX);
  localparam int TYPE_W     = 2;
  localparam int DOM_LSB    = 24;
  localparam int NRM_S1_BIT = 19;
  localparam int NRM_S0_BIT = 18;
  localparam int RSV_LSB    = 20;
  localparam int RSV_MSB    = 23;
  localparam int NUM_BANKS  = 2;

  typedef enum logic [TYPE_W-1:0] {
    MT_STRONG = 2'b00,
    MT_DEVICE = 2'b01,
    MT_NORMAL = 2'b10,
    MT_RSVD   = 2'b11
  } mem_type_e;

  function automatic logic [REG_W-1:0] keep_mask();
    logic [REG_W-1:0] m;
    m = '1;
    for (int i = RSV_LSB; i <= RSV_MSB; i++) m[i] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/remap_gate.sv
module remap_gate #(
  parameter int EL_W   = 2,
  parameter int MIN_EL = 1
) (
  input  logic            req,
  input  logic [EL_W-1:0] el,
  input  logic            long_desc,
  output logic            grant,
  output logic            refuse
);
  logic level_ok;

  always_comb begin
    level_ok = (32'(el) >= MIN_EL);
    grant    = req && level_ok && !long_desc;
    refuse   = req && !grant;
  end
endmodule

// File: rtl/remap_bank.sv
module remap_bank
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel_a,
  output logic [REG_W-1:0] rd_data_a,
  input  logic             rd_sel_b,
  output logic [REG_W-1:0] rd_data_b
);
  localparam logic [REG_W-1:0] MASK = keep_mask();

  logic [REG_W-1:0] bank_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             en;
    logic [REG_W-1:0] nxt;

    always_comb begin
      en  = wr_en && (32'(wr_sel) == g);
      nxt = wr_data & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank_q[g] <= '0;
      else if (en) bank_q[g] <= nxt;
    end

    // R5
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_q[g][RSV_MSB:RSV_LSB] == '0);

    // R6
    bank_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (32'(wr_sel) != g)) |=> $stable(bank_q[g]));
  end

  always_comb begin
    rd_data_a = bank_q[rd_sel_a];
    rd_data_b = bank_q[rd_sel_b];
  end
endmodule

// File: rtl/remap_resolve.sv
module remap_resolve
  import remap_pkg::*;
(
  input  logic [REG_W-1:0]  ctrl,
  input  logic [IDX_W-1:0]  idx,
  input  logic              s_bit,
  output logic [TYPE_W-1:0] mtype,
  output logic              shareable,
  output logic              inner,
  output logic              rsvd
);
  always_comb begin
    mtype     = ctrl[TYPE_W*idx +: TYPE_W];
    shareable = 1'b0;
    inner     = 1'b0;
    rsvd      = 1'b0;
    unique case (mem_type_e'(mtype))
      MT_STRONG, MT_DEVICE: shareable = 1'b1;
      MT_NORMAL: begin
        shareable = s_bit ? ctrl[NRM_S1_BIT] : ctrl[NRM_S0_BIT];
        inner     = shareable && ctrl[DOM_LSB + 32'(idx)];
      end
      default: rsvd = 1'b1;
    endcase
  end

  // R3, R4
  always_comb begin
    dom_only_normal_chk: assert (!inner || (shareable && mtype == MT_NORMAL));
  end
endmodule

// File: rtl/attr_remap_unit.sv
module attr_remap_unit
  import remap_pkg::*;
#(
  parameter int EL_W   = 2,
  parameter int MIN_EL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic             cfg_we,
  input  logic [EL_W-1:0]  cfg_el,
  input  logic             cfg_ns,
  input  logic             cfg_long_desc,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             cfg_err,
  input  logic             lkp_valid,
  input  logic             lkp_ns,
  input  logic             lkp_tex0,
  input  logic             lkp_c,
  input  logic             lkp_b,
  input  logic             lkp_s,
  output logic [TYPE_W-1:0] lkp_type,
  output logic             lkp_shareable,
  output logic             lkp_inner,
  output logic             lkp_err
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic grant, refuse;

  remap_gate #(.EL_W(EL_W), .MIN_EL(MIN_EL)) u_gate (
    .req       (cfg_req),
    .el        (cfg_el),
    .long_desc (cfg_long_desc),
    .grant     (grant),
    .refuse    (refuse)
  );

  logic [REG_W-1:0] cfg_word, lkp_word;
  logic             wr_en;

  assign wr_en = grant && cfg_we;

  remap_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .wr_sel    (cfg_ns),
    .wr_data   (cfg_wdata),
    .rd_sel_a  (cfg_ns),
    .rd_data_a (cfg_word),
    .rd_sel_b  (lkp_ns),
    .rd_data_b (lkp_word)
  );

  logic [IDX_W-1:0] lkp_idx;
  logic             lkp_rsvd;

  assign lkp_idx = {lkp_tex0, lkp_c, lkp_b};

  remap_resolve u_resolve (
    .ctrl      (lkp_word),
    .idx       (lkp_idx),
    .s_bit     (lkp_s),
    .mtype     (lkp_type),
    .shareable (lkp_shareable),
    .inner     (lkp_inner),
    .rsvd      (lkp_rsvd)
  );

  assign cfg_rdata = (grant && !cfg_we) ? cfg_word : '0;

  logic cfg_err_d, cfg_err_q, lkp_err_d, lkp_err_q;

  always_comb begin
    cfg_err_d = refuse;
    lkp_err_d = lkp_valid && lkp_rsvd;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cfg_err_q <= 1'b0;
      lkp_err_q <= 1'b0;
    end else begin
      cfg_err_q <= cfg_err_d;
      lkp_err_q <= lkp_err_d;
    end
  end

  assign cfg_err = cfg_err_q;
  assign lkp_err = lkp_err_q;

  // R7
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_req && 32'(cfg_el) < MIN_EL) |-> (cfg_rdata == '0));

  // R8
  long_desc_err_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_req && cfg_long_desc) |=> cfg_err);

  // R9
  rsvd_lookup_err_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lkp_valid && lkp_type == MT_RSVD) |=> lkp_err);

  // R9
  rsvd_no_share_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lkp_type == MT_RSVD) |-> (!lkp_shareable && !lkp_inner));

  // R7
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(cfg_req) |-> !cfg_err);
endmodule

// File: tb/tb_attr_remap_unit.sv
module tb_attr_remap_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_req, cfg_we, cfg_ns, cfg_long_desc;
  logic [1:0]  cfg_el;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        cfg_err;
  logic        lkp_valid, lkp_ns, lkp_tex0, lkp_c, lkp_b, lkp_s;
  logic [1:0]  lkp_type;
  logic        lkp_shareable, lkp_inner, lkp_err;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [2];
  logic exp_cfg_err, exp_lkp_err;

  always #2.5 clk = ~clk;

  attr_remap_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lookup(input logic [31:0] r, input logic [2:0] n, input logic s);
    logic [1:0] t;
    logic sh, in;
    t = r[2*n +: 2];
    sh = 1'b0; in = 1'b0;
    if (t == 2'b10) begin
      sh = s ? r[19] : r[18];
      in = sh & r[24+n];
    end else if (t != 2'b11) begin
      sh = 1'b1;
    end
    return {t, sh, in};
  endfunction

  // One cycle: check previous error pulses, drive, check combinational results, update model.
  task automatic step(input logic req, input logic we, input logic [1:0] el, input logic ns,
                      input logic ld, input logic [31:0] wd,
                      input logic lv, input logic lns, input logic [2:0] n, input logic s);
    logic granted;
    logic [3:0] el_exp;
    @(negedge clk);
    chk("R7/R8 cfg_err", 32'(cfg_err), 32'(exp_cfg_err));
    chk("R9 lkp_err", 32'(lkp_err), 32'(exp_lkp_err));
    cfg_req = req; cfg_we = we; cfg_el = el; cfg_ns = ns; cfg_long_desc = ld; cfg_wdata = wd;
    lkp_valid = lv; lkp_ns = lns; {lkp_tex0, lkp_c, lkp_b} = n; lkp_s = s;
    #1;
    granted = req && (el >= 2'd1) && !ld;
    chk("R10/R7 cfg_rdata", cfg_rdata, (granted && !we) ? model[ns] : 32'h0);
    el_exp = exp_lookup(model[lns], n, s);
    chk("R1-R4,R6 lookup", {28'h0, lkp_type, lkp_shareable, lkp_inner}, {28'h0, el_exp});
    exp_cfg_err = req && !granted;
    exp_lkp_err = lv && (el_exp[3:2] == 2'b11);
    if (granted && we) model[ns] = wd & 32'hFF0F_FFFF;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [3:0] a, b2;
    seed = 32'd1234;
    void'($urandom(seed));
    model[0] = '0; model[1] = '0;
    exp_cfg_err = 0; exp_lkp_err = 0;
    cfg_req = 0; cfg_we = 0; cfg_el = 0; cfg_ns = 0; cfg_long_desc = 0; cfg_wdata = 0;
    lkp_valid = 0; lkp_ns = 0; lkp_tex0 = 0; lkp_c = 0; lkp_b = 0; lkp_s = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset cfg_err", 32'(cfg_err), 0);
    chk("R10 reset lkp_err", 32'(lkp_err), 0);
    chk("R10 reset lookup type", 32'(lkp_type), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R10: reset contents read as zero in both copies
    step(1, 0, 1, 0, 0, 0, 1, 0, 3'd5, 1);
    step(1, 0, 1, 1, 0, 0, 1, 1, 3'd2, 0);
    // R5: all-ones write, reserved bits dropped
    step(1, 1, 3, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 0, 2, 1, 0, 0, 1, 1, 3'd7, 1);
    chk("R5 readback", cfg_rdata, 32'hFF0F_FFFF);
    // R6: Secure copy untouched
    step(1, 0, 1, 0, 0, 0, 1, 0, 3'd7, 1);
    chk("R6 secure copy", cfg_rdata, 32'h0);
    // R7: level 0 write refused
    step(1, 1, 0, 0, 0, 32'h0000_AAAA, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 refused write", cfg_rdata, 32'h0);
    // R8: long-descriptor refuses at high level
    step(1, 1, 3, 0, 1, 32'h0000_AAAA, 0, 0, 0, 0);
    step(1, 0, 3, 0, 1, 0, 0, 0, 0, 0);
    step(1, 0, 3, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 refused write", cfg_rdata, 32'h0);
    // R2/R3: Normal at index 3, S1 shareable inner, S0 not shareable
    step(1, 1, 1, 0, 0, 32'h0808_0080, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 3'd3, 1);
    chk("R3 inner", {31'h0, lkp_inner}, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 3'd3, 0);
    chk("R2 S0 not shareable", {31'h0, lkp_shareable}, 0);
    // R4: device bits 17/16 do not change a device lookup
    step(1, 1, 1, 0, 0, 32'h0000_0001, 1, 0, 3'd0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 1);
    a = {lkp_type, lkp_shareable, lkp_inner};
    step(1, 1, 1, 0, 0, 32'h0003_0001, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 1);
    b2 = {lkp_type, lkp_shareable, lkp_inner};
    chk("R4 device bits ignored", 32'(b2), 32'(a));
    chk("R4 device result", 32'(b2), 32'(4'b0110));
    // R9: reserved type at index 1
    step(1, 1, 1, 1, 0, 32'h0000_000C, 1, 1, 3'd1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 1, 3'd1, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[3:2], r[4], (r[7:5] == 3'd0), $urandom,
           r[8], r[9], r[12:10], r[13]);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule